// File: doc/BRIEF.md
# Bit-Manipulation Execution Unit

This unit executes the single-bit and masked-bit memory instructions of an 8-bit processor core with a 16-bit address space. The core's main fetch path hands over one instruction at a time with a one-clock start pulse, giving the opcode byte, the address of that opcode byte (the current program counter) and the accumulator value. The unit then owns a simple synchronous memory port until it finishes. It fetches the zero-page address operand and, for branches, a signed displacement. It reads the addressed zero-page byte and writes the modified byte back where the instruction calls for it. At the end it returns a one-clock done pulse that carries the next program counter, a zero-flag result with its qualifier, a branch-taken indication and an error flag.

There are three instruction families. The first clears or sets one chosen bit of a zero-page byte. The second branches when a chosen bit of a zero-page byte is clear, or when it is set. The third tests a zero-page byte against the accumulator and then clears or sets the accumulator's bits in that byte. Any other opcode is rejected with an error and causes no memory access.

The memory port presents an address with a read strobe. The memory samples that request on the next rising edge and drives the byte on its read-data input from then on. A write is one clock wide and carries its address and data in that same clock.

Top module: `bitop_exec_unit`

## Requirements
- R1: While reset is high and in the clock after reset is released, done_o, err_o, z_valid_o, taken_o, mem_rd_o and mem_wr_o are all 0.
- R2: Opcode 0x07 + 0x10·n (n = 0..7, n taken from opcode bits 6:4) reads the zero-page byte at address {0x00, operand}, clears only bit n and writes the result back to the same address. It returns next_pc = pc + 2, with z_valid_o = 0 and taken_o = 0.
- R3: Opcode 0x87 + 0x10·n sets only bit n of the addressed zero-page byte and writes the result back to the same address. It returns next_pc = pc + 2, with z_valid_o = 0 and taken_o = 0.
- R4: Opcode 0x0F + 0x10·n (operands: zero-page address at pc+1, displacement at pc+2) branches only when bit n of the zero-page byte is 0. A taken branch returns next_pc = pc + 3 + sign-extended displacement and taken_o = 1. A branch that is not taken returns next_pc = pc + 3 and taken_o = 0. No memory write occurs.
- R5: Opcode 0x8F + 0x10·n behaves like R4 but branches only when bit n is 1.
- R6: Opcode 0x14 returns z_o = 1 exactly when (memory AND accumulator) is 0, with z_valid_o = 1. It writes back memory AND NOT accumulator and returns next_pc = pc + 2.
- R7: Opcode 0x04 returns z_o as in R6, with z_valid_o = 1. It writes back memory OR accumulator and returns next_pc = pc + 2.
- R8: For every supported opcode, done_o is a one-clock pulse that rises on the fifth rising edge after the edge that accepted start_i. Any write is a single one-clock pulse in the clock just before done_o.
- R9: A supported non-branch opcode makes exactly 2 reads and a branch opcode makes exactly 3. mem_rd_o and mem_wr_o are never high together.
- R10: An unsupported opcode raises err_o together with a done_o pulse on the first rising edge after acceptance. It returns next_pc = pc, makes no read or write, and leaves z_valid_o and taken_o at 0.
- R11: A start_i pulse while an instruction is in progress is ignored: the running instruction completes unchanged and no extra done_o follows.
- R12: Branch target arithmetic wraps modulo 65536, both backwards (negative displacement) and past 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-clock request to execute the presented opcode |
| opcode_i | input | 8 | Opcode byte, sampled with start_i |
| pc_i | input | 16 | Address of the opcode byte, sampled with start_i |
| acc_i | input | 8 | Accumulator value, sampled with start_i |
| mem_addr_o | output | 16 | Memory address for the read or the write |
| mem_rd_o | output | 1 | Read request |
| mem_wr_o | output | 1 | Write strobe, one clock wide |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid from the edge after the read request |
| done_o | output | 1 | One-clock completion pulse |
| next_pc_o | output | 16 | Program counter for the following instruction, valid with done_o |
| z_o | output | 1 | Zero-flag result, meaningful when z_valid_o is 1 |
| z_valid_o | output | 1 | High with done_o for the two test-and-modify opcodes only |
| taken_o | output | 1 | High with done_o when a bit branch was taken |
| err_o | output | 1 | High with done_o for an unsupported opcode |

## Verification
The bit families are run over all eight bit positions. Clear-bit operations start from an all-ones byte and set-bit operations start from an all-zeros byte, so a wrong mask or a shifted bit index shows up in the written byte. A neighbouring byte is also checked to catch a write to the wrong address. Branches are driven with one lone bit against a byte that disagrees on every position, which separates taken from not taken and exposes an inverted sense. Forward, backward and wrapping displacements separate the three-byte base from the two-byte base and catch a missing sign extension. The test-and-modify opcodes are given accumulator patterns that do and do not overlap memory, which separates the zero result from the write-back value. Unsupported opcodes and a start pulse sent mid-instruction confirm that nothing is touched.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  localparam int OPC_W   = 8;
  localparam int BYTE_W  = 8;
  localparam int SEL_W   = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    K_BAD,
    K_CLRBIT,
    K_SETBIT,
    K_BRCLR,
    K_BRSET,
    K_TCLR,
    K_TSET
  } op_kind_e;

  typedef struct packed {
    op_kind_e           kind;
    logic [SEL_W-1:0]   bit_sel;
  } op_dec_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPA,
    ST_OPB,
    ST_WAIT,
    ST_DATA,
    ST_FIN
  } seq_st_e;

  function automatic logic kind_is_branch(op_kind_e k);
    return (k == K_BRCLR) || (k == K_BRSET);
  endfunction

  function automatic logic kind_is_test(op_kind_e k);
    return (k == K_TCLR) || (k == K_TSET);
  endfunction

  function automatic logic kind_writes(op_kind_e k);
    return (k == K_CLRBIT) || (k == K_SETBIT) || kind_is_test(k);
  endfunction

endpackage

// File: rtl/bitop_decoder.sv
module bitop_decoder
  import bitop_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output op_dec_t          dec_o
);

  always_comb begin
    dec_o.kind    = K_BAD;
    dec_o.bit_sel = opcode_i[SEL_W+3:4];
    case (opcode_i[3:0])
      4'h7: dec_o.kind = opcode_i[7] ? K_SETBIT : K_CLRBIT;
      4'hF: dec_o.kind = opcode_i[7] ? K_BRSET  : K_BRCLR;
      4'h4: begin
        if (opcode_i[7:4] == 4'h0)
          dec_o.kind = K_TSET;
        else if (opcode_i[7:4] == 4'h1)
          dec_o.kind = K_TCLR;
      end
      default: dec_o.kind = K_BAD;
    endcase
  end

endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
#(
  parameter int DATA_W = BYTE_W,
  localparam int SW    = $clog2(DATA_W)
)(
  input  op_kind_e          kind_i,
  input  logic [SW-1:0]     sel_i,
  input  logic [DATA_W-1:0] mem_i,
  input  logic [DATA_W-1:0] acc_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic              bit_o,
  output logic              zero_o
);

  logic [DATA_W-1:0] mask;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign mask[i] = (sel_i == SW'(i));
  end

  assign bit_o  = |(mem_i & mask);
  assign zero_o = ~|(mem_i & acc_i);

  always_comb begin
    case (kind_i)
      K_CLRBIT: wdata_o = mem_i & ~mask;
      K_SETBIT: wdata_o = mem_i | mask;
      K_TCLR:   wdata_o = mem_i & ~acc_i;
      K_TSET:   wdata_o = mem_i | acc_i;
      default:  wdata_o = mem_i;
    endcase
  end

endmodule

// File: rtl/bitop_next_pc.sv
module bitop_next_pc
  import bitop_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = BYTE_W
)(
  input  op_kind_e          kind_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] disp_i,
  input  logic              bit_i,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              taken_o
);

  localparam int EXT_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] target;

  assign seq_pc   = pc_i + (kind_is_branch(kind_i) ? ADDR_W'(3) : ADDR_W'(2));
  assign disp_ext = {{EXT_W{disp_i[DATA_W-1]}}, disp_i};
  assign target   = seq_pc + disp_ext;

  assign taken_o   = ((kind_i == K_BRCLR) && !bit_i) ||
                     ((kind_i == K_BRSET) &&  bit_i);
  assign next_pc_o = taken_o ? target : seq_pc;

endmodule

// File: rtl/bitop_sequencer.sv
module bitop_sequencer
  import bitop_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = BYTE_W,
  localparam int SW    = $clog2(DATA_W),
  localparam int PG_W  = ADDR_W - DATA_W
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  op_dec_t           dec_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  // datapath hooks
  output op_kind_e          kind_o,
  output logic [SW-1:0]     sel_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] disp_o,
  input  logic [DATA_W-1:0] alu_wdata_i,
  input  logic              alu_zero_i,
  input  logic [ADDR_W-1:0] npc_i,
  input  logic              taken_i,
  // memory port
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  // completion
  output logic              done_o,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              z_o,
  output logic              z_valid_o,
  output logic              taken_o,
  output logic              err_o,
  output logic              busy_o
);

  localparam logic [PG_W-1:0] ZP_PAGE = '0;

  seq_st_e           state;
  op_kind_e          kind_q;
  logic [SW-1:0]     sel_q;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] zp_q;
  logic [DATA_W-1:0] disp_q;

  logic [ADDR_W-1:0] res_pc;
  logic              res_z;
  logic              res_zv;
  logic              res_tk;
  logic              res_err;

  assign kind_o = kind_q;
  assign sel_o  = sel_q;
  assign acc_o  = acc_q;
  assign pc_o   = pc_q;
  assign disp_o = disp_q;
  assign busy_o = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      kind_q      <= K_BAD;
      sel_q       <= '0;
      pc_q        <= '0;
      acc_q       <= '0;
      zp_q        <= '0;
      disp_q      <= '0;
      res_pc      <= '0;
      res_z       <= 1'b0;
      res_zv      <= 1'b0;
      res_tk      <= 1'b0;
      res_err     <= 1'b0;
      mem_addr_o  <= '0;
      mem_rd_o    <= 1'b0;
      mem_wr_o    <= 1'b0;
      mem_wdata_o <= '0;
      done_o      <= 1'b0;
      next_pc_o   <= '0;
      z_o         <= 1'b0;
      z_valid_o   <= 1'b0;
      taken_o     <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      mem_rd_o  <= 1'b0;
      mem_wr_o  <= 1'b0;
      done_o    <= 1'b0;
      z_valid_o <= 1'b0;
      taken_o   <= 1'b0;
      err_o     <= 1'b0;

      case (state)
        ST_IDLE: begin
          if (start_i) begin
            kind_q <= dec_i.kind;
            sel_q  <= dec_i.bit_sel;
            pc_q   <= pc_i;
            acc_q  <= acc_i;
            if (dec_i.kind == K_BAD) begin
              res_pc  <= pc_i;
              res_err <= 1'b1;
              res_z   <= 1'b0;
              res_zv  <= 1'b0;
              res_tk  <= 1'b0;
              state   <= ST_FIN;
            end else begin
              res_err    <= 1'b0;
              mem_addr_o <= pc_i + ADDR_W'(1);
              mem_rd_o   <= 1'b1;
              state      <= ST_OPA;
            end
          end
        end

        ST_OPA: begin
          if (kind_is_branch(kind_q)) begin
            mem_addr_o <= pc_q + ADDR_W'(2);
            mem_rd_o   <= 1'b1;
          end
          state <= ST_OPB;
        end

        ST_OPB: begin
          zp_q       <= mem_rdata_i;
          mem_addr_o <= {ZP_PAGE, mem_rdata_i};
          mem_rd_o   <= 1'b1;
          state      <= ST_WAIT;
        end

        ST_WAIT: begin
          if (kind_is_branch(kind_q))
            disp_q <= mem_rdata_i;
          state <= ST_DATA;
        end

        ST_DATA: begin
          if (kind_writes(kind_q)) begin
            mem_wr_o    <= 1'b1;
            mem_addr_o  <= {ZP_PAGE, zp_q};
            mem_wdata_o <= alu_wdata_i;
          end
          res_pc <= npc_i;
          res_tk <= taken_i;
          res_zv <= kind_is_test(kind_q);
          res_z  <= kind_is_test(kind_q) && alu_zero_i;
          state  <= ST_FIN;
        end

        ST_FIN: begin
          done_o    <= 1'b1;
          next_pc_o <= res_pc;
          z_o       <= res_z;
          z_valid_o <= res_zv;
          taken_o   <= res_tk;
          err_o     <= res_err;
          state     <= ST_IDLE;
        end

        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bitop_exec_unit.sv
module bitop_exec_unit
  import bitop_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = BYTE_W
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] acc_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              z_o,
  output logic              z_valid_o,
  output logic              taken_o,
  output logic              err_o
);

  localparam int SW = $clog2(DATA_W);

  op_dec_t           dec;
  op_kind_e          kind;
  logic [SW-1:0]     sel;
  logic [DATA_W-1:0] acc_q;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] disp_q;
  logic [DATA_W-1:0] alu_wdata;
  logic              alu_bit;
  logic              alu_zero;
  logic [ADDR_W-1:0] npc;
  logic              br_taken;
  logic              seq_busy;

  bitop_decoder u_dec (
    .opcode_i (opcode_i),
    .dec_o    (dec)
  );

  bitop_alu #(.DATA_W(DATA_W)) u_alu (
    .kind_i  (kind),
    .sel_i   (sel),
    .mem_i   (mem_rdata_i),
    .acc_i   (acc_q),
    .wdata_o (alu_wdata),
    .bit_o   (alu_bit),
    .zero_o  (alu_zero)
  );

  bitop_next_pc #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_npc (
    .kind_i    (kind),
    .pc_i      (pc_q),
    .disp_i    (disp_q),
    .bit_i     (alu_bit),
    .next_pc_o (npc),
    .taken_o   (br_taken)
  );

  bitop_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .dec_i       (dec),
    .pc_i        (pc_i),
    .acc_i       (acc_i),
    .mem_rdata_i (mem_rdata_i),
    .kind_o      (kind),
    .sel_o       (sel),
    .acc_o       (acc_q),
    .pc_o        (pc_q),
    .disp_o      (disp_q),
    .alu_wdata_i (alu_wdata),
    .alu_zero_i  (alu_zero),
    .npc_i       (npc),
    .taken_i     (br_taken),
    .mem_addr_o  (mem_addr_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .mem_wdata_o (mem_wdata_o),
    .done_o      (done_o),
    .next_pc_o   (next_pc_o),
    .z_o         (z_o),
    .z_valid_o   (z_valid_o),
    .taken_o     (taken_o),
    .err_o       (err_o),
    .busy_o      (seq_busy)
  );

endmodule

// File: rtl/bitop_exec_unit_chk.sv
module bitop_exec_unit_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
)(
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              busy,
  input logic              done_o,
  input logic              err_o,
  input logic              z_valid_o,
  input logic              taken_o,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic [ADDR_W-1:0] mem_addr_o
);

  logic [2:0] age;
  logic       touched;
  logic       accept;

  assign accept = start_i && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      age     <= '0;
      touched <= 1'b0;
    end else begin
      if (accept)
        age <= 3'd1;
      else if (done_o)
        age <= '0;
      else if (age != '0 && age != 3'd7)
        age <= age + 3'd1;

      if (accept)
        touched <= 1'b0;
      else if (mem_rd_o || mem_wr_o)
        touched <= 1'b1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> !(done_o || err_o || mem_wr_o || mem_rd_o || z_valid_o || taken_o));

  // R8
  wr_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_o |=> !mem_wr_o);

  // R8
  wr_before_done_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_o |=> done_o);

  // R8
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8
  done_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !err_o) |-> (age == 3'd6));

  // R10
  err_latency_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (done_o && age == 3'd2 && !touched));

  // R9
  rd_wr_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_o && mem_wr_o));

  // R2
  wr_zero_page_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_o |-> (mem_addr_o[ADDR_W-1:DATA_W] == '0));

  // R4
  qualifier_chk: assert property (@(posedge clk) disable iff (rst)
    (taken_o || z_valid_o) |-> (done_o && !err_o && !(taken_o && z_valid_o)));

  // R11
  idle_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy);

endmodule

bind bitop_exec_unit bitop_exec_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .busy       (seq_busy),
  .done_o     (done_o),
  .err_o      (err_o),
  .z_valid_o  (z_valid_o),
  .taken_o    (taken_o),
  .mem_rd_o   (mem_rd_o),
  .mem_wr_o   (mem_wr_o),
  .mem_addr_o (mem_addr_o)
);

// File: tb/bitop_exec_unit_bench.sv
module bitop_exec_unit_bench;

  localparam int LAT_OK  = 6;  // negedges from start drive to done: accept edge + 5 clocks
  localparam int LAT_ERR = 2;  // accept edge + 1 clock

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [7:0]  opcode_i = '0;
  logic [15:0] pc_i = '0;
  logic [7:0]  acc_i = '0;
  logic [15:0] mem_addr_o;
  logic        mem_rd_o;
  logic        mem_wr_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata_i = '0;
  logic        done_o;
  logic [15:0] next_pc_o;
  logic        z_o;
  logic        z_valid_o;
  logic        taken_o;
  logic        err_o;

  always #4 clk = ~clk;

  bitop_exec_unit u_bitop_exec_unit (
    .clk(clk), .rst(rst), .start_i(start_i), .opcode_i(opcode_i),
    .pc_i(pc_i), .acc_i(acc_i), .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o),
    .mem_wr_o(mem_wr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .done_o(done_o), .next_pc_o(next_pc_o), .z_o(z_o), .z_valid_o(z_valid_o),
    .taken_o(taken_o), .err_o(err_o)
  );

  // small memory model, address folded to 1 KiB
  logic [7:0] mem [0:1023];
  int wr_total = 0;
  int rd_total = 0;
  int done_total = 0;

  always @(posedge clk) begin
    if (mem_wr_o) begin
      mem[mem_addr_o[9:0]] <= mem_wdata_o;
      wr_total <= wr_total + 1;
    end
    if (mem_rd_o) begin
      mem_rdata_i <= mem[mem_addr_o[9:0]];
      rd_total <= rd_total + 1;
    end
    if (done_o) done_total <= done_total + 1;
  end

  int n_chk = 0;
  int n_fail = 0;

  int          r_lat, r_wr, r_rd;
  logic [15:0] r_pc;
  logic        r_z, r_zv, r_tk, r_err;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic poke(input logic [15:0] a, input logic [7:0] d);
    mem[a[9:0]] = d;
  endtask

  task automatic run_op(input logic [7:0] opc, input logic [15:0] pc, input logic [7:0] acc);
    int w0, r0;
    w0 = wr_total;
    r0 = rd_total;
    start_i  = 1'b1;
    opcode_i = opc;
    pc_i     = pc;
    acc_i    = acc;
    @(negedge clk);
    start_i = 1'b0;
    r_lat = 1;
    while (!done_o && r_lat < 40) begin
      @(negedge clk);
      r_lat++;
    end
    r_pc  = next_pc_o;
    r_z   = z_o;
    r_zv  = z_valid_o;
    r_tk  = taken_o;
    r_err = err_o;
    @(negedge clk);
    r_wr = wr_total - w0;
    r_rd = rd_total - r0;
  endtask

  task automatic t_reset();
    chk("R1", "quiet outputs after reset",
        int'({done_o, err_o, mem_wr_o, mem_rd_o, z_valid_o, taken_o}), 0);
  endtask

  task automatic t_clrbit();
    for (int n = 0; n < 8; n++) begin
      poke(16'h0100, 8'h07 + 8'(n * 16));
      poke(16'h0101, 8'h43);
      poke(16'h0043, 8'hFF);
      poke(16'h0044, 8'hA5);
      run_op(8'h07 + 8'(n * 16), 16'h0100, 8'h00);
      chk("R2", "clear-bit result byte", mem[16'h0043], 8'hFF & ~(8'h01 << n));
      chk("R2", "clear-bit neighbour intact", mem[16'h0044], 8'hA5);
      chk("R2", "clear-bit next pc", r_pc, 16'h0102);
      chk("R2", "clear-bit flags zv/tk/err", int'({r_zv, r_tk, r_err}), 0);
      chk("R8", "clear-bit latency", r_lat, LAT_OK);
      chk("R8", "clear-bit write count", r_wr, 1);
      chk("R9", "clear-bit read count", r_rd, 2);
    end
  endtask

  task automatic t_setbit();
    for (int n = 0; n < 8; n++) begin
      poke(16'h0120, 8'h87 + 8'(n * 16));
      poke(16'h0121, 8'h80);
      poke(16'h0080, 8'h00);
      run_op(8'h87 + 8'(n * 16), 16'h0120, 8'hFF);
      chk("R3", "set-bit result byte", mem[16'h0080], 8'h01 << n);
      chk("R3", "set-bit next pc", r_pc, 16'h0122);
      chk("R3", "set-bit flags zv/tk", int'({r_zv, r_tk}), 0);
      chk("R8", "set-bit write count", r_wr, 1);
    end
  endtask

  task automatic t_branch_bit();
    // lone clear bit 6 -> branch-on-clear bit 6 taken
    poke(16'h0000, 8'h6F); poke(16'h0001, 8'hFE); poke(16'h0002, 8'h40);
    poke(16'h00FE, 8'hBF);
    run_op(8'h6F, 16'h0000, 8'h00);
    chk("R4", "clear-branch taken target", r_pc, 16'h0043);
    chk("R4", "clear-branch taken flag", r_tk, 1);
    chk("R4", "clear-branch no write", r_wr, 0);
    chk("R9", "branch read count", r_rd, 3);
    chk("R8", "branch latency", r_lat, LAT_OK);
    // all bits set -> no clear-branch taken
    poke(16'h00FE, 8'hFF);
    for (int n = 0; n < 8; n++) begin
      poke(16'h0000, 8'h0F + 8'(n * 16));
      run_op(8'h0F + 8'(n * 16), 16'h0000, 8'h00);
      chk("R4", "clear-branch not taken pc", r_pc, 16'h0003);
      chk("R4", "clear-branch not taken flag", r_tk, 0);
    end
    // lone set bit 6 -> branch-on-set bit 6 taken
    poke(16'h0000, 8'hEF);
    poke(16'h00FE, 8'h40);
    run_op(8'hEF, 16'h0000, 8'h00);
    chk("R5", "set-branch taken target", r_pc, 16'h0043);
    chk("R5", "set-branch taken flag", r_tk, 1);
    chk("R5", "set-branch no write", r_wr, 0);
    poke(16'h00FE, 8'h00);
    for (int n = 0; n < 8; n++) begin
      poke(16'h0000, 8'h8F + 8'(n * 16));
      run_op(8'h8F + 8'(n * 16), 16'h0000, 8'h00);
      chk("R5", "set-branch not taken pc", r_pc, 16'h0003);
      chk("R5", "set-branch not taken flag", r_tk, 0);
    end
  endtask

  task automatic t_wrap();
    // backward displacement
    poke(16'h0200, 8'h8F); poke(16'h0201, 8'h30); poke(16'h0202, 8'hF0);
    poke(16'h0030, 8'h01);
    run_op(8'h8F, 16'h0200, 8'h00);
    chk("R12", "backward target", r_pc, 16'h01F3);
    // forward past 0xFFFF
    poke(16'hFFF0, 8'h1F); poke(16'hFFF1, 8'h31); poke(16'hFFF2, 8'h7F);
    poke(16'h0031, 8'hFD);
    run_op(8'h1F, 16'hFFF0, 8'h00);
    chk("R12", "wrapping target", r_pc, 16'h0072);
    chk("R12", "wrapping taken", r_tk, 1);
  endtask

  task automatic t_test_ops();
    // set-under-mask, no overlap
    poke(16'h0300, 8'h04); poke(16'h0301, 8'h50); poke(16'h0050, 8'hF0);
    run_op(8'h04, 16'h0300, 8'h0F);
    chk("R7", "test-set write", mem[16'h0050], 8'hFF);
    chk("R7", "test-set zero (no overlap)", int'({r_zv, r_z}), 3);
    chk("R7", "test-set next pc", r_pc, 16'h0302);
    // set-under-mask, overlap
    poke(16'h0050, 8'h10);
    run_op(8'h04, 16'h0300, 8'h11);
    chk("R7", "test-set write overlap", mem[16'h0050], 8'h11);
    chk("R7", "test-set zero (overlap)", int'({r_zv, r_z}), 2);
    // clear-under-mask, overlap
    poke(16'h0300, 8'h14); poke(16'h0050, 8'h3C);
    run_op(8'h14, 16'h0300, 8'h0F);
    chk("R6", "test-clear write overlap", mem[16'h0050], 8'h30);
    chk("R6", "test-clear zero (overlap)", int'({r_zv, r_z}), 2);
    chk("R8", "test-clear latency", r_lat, LAT_OK);
    // clear-under-mask, no overlap
    poke(16'h0050, 8'h7F);
    run_op(8'h14, 16'h0300, 8'h80);
    chk("R6", "test-clear write no overlap", mem[16'h0050], 8'h7F);
    chk("R6", "test-clear zero (no overlap)", int'({r_zv, r_z}), 3);
    chk("R6", "test-clear next pc", r_pc, 16'h0302);
  endtask

  task automatic t_bad();
    logic [7:0] bad [4] = '{8'h00, 8'h24, 8'hEA, 8'h03};
    for (int i = 0; i < 4; i++) begin
      run_op(bad[i], 16'h0345, 8'h55);
      chk("R10", "error flag", r_err, 1);
      chk("R10", "error latency", r_lat, LAT_ERR);
      chk("R10", "error pc unchanged", r_pc, 16'h0345);
      chk("R10", "error no access", r_wr + r_rd, 0);
      chk("R10", "error zv/tk", int'({r_zv, r_tk}), 0);
    end
  endtask

  task automatic t_busy();
    int d0;
    poke(16'h0140, 8'hB7); poke(16'h0141, 8'h60); poke(16'h0060, 8'h00);
    d0 = done_total;
    start_i = 1'b1; opcode_i = 8'hB7; pc_i = 16'h0140; acc_i = 8'h00;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    start_i = 1'b1; opcode_i = 8'h00; pc_i = 16'h0999;   // must be ignored
    @(negedge clk);
    start_i = 1'b0;
    repeat (12) @(negedge clk);
    chk("R11", "single done for overlapped start", done_total - d0, 1);
    chk("R11", "running op result intact", mem[16'h0060], 8'h08);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_clrbit();
    t_setbit();
    t_branch_bit();
    t_wrap();
    t_test_ops();
    t_bad();
    t_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog: actual hung expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule